// File: doc/BRIEF.md
# Paged Indirect Bus Bridge

This block gives a host that can only move 16-bit register values a window into a 32-bit internal address space. The host talks to a small register file of 5-bit register addresses. One register, reachable from every page, holds the current page number. When that number equals the bridge page, a group of bridge registers becomes visible: a mode register, staging halves for a write address and write data, staging halves for a read address, and the two halves of the last word read back.

The host builds every 32-bit value from two 16-bit halves. Writing the low data half launches an internal write of the staged word to the staged write address. Writing the low read-address half launches an internal read, and the returned word lands in the read-data halves. In auto-increment mode the write address steps forward by one word after every launched write, so a block of words streams in as data-high/data-low pairs after a single address setup. The internal side is a valid/ready request channel that tolerates any number of wait states. While a transfer is in flight the bridge reports busy and holds off any host access that would launch another one.

Top module: `pib_bridge`

## Requirements
- R1: After reset the page register reads 0, auto-increment is off, all staging and read-data halves read 0, `ib_valid` is low and `host_ready` is high.
- R2: The page register sits at register address 0x1F and is readable and writable on every page; the bridge registers at 0x10 to 0x18 respond only while the page register holds 4, and otherwise read as 0 and ignore writes (no internal transfer starts).
- R3: The mode register at 0x10 stores bit 15 (1 = auto-increment, 0 = fixed address); reading it returns that bit in bit 15, the busy flag in bit 0, and 0 in all other bits.
- R4: Write-address high/low (0x11/0x12), write-data high/low (0x13/0x14) and read-address high/low (0x15/0x16) read back what was last written; writes to 0x11, 0x12, 0x13 and 0x15 only stage and start no internal transfer.
- R5: A host write to 0x14 launches one internal write with address {0x11, 0x12} and data {0x13, value written}, high half in bits 31:16.
- R6: A host write to 0x16 launches one internal read at address {0x15, value written}; on its acknowledge bits 31:16 of the returned word appear at 0x17 and bits 15:0 at 0x18; host writes to 0x17 and 0x18 are ignored.
- R7: In auto-increment mode the 32-bit write address in {0x11, 0x12} grows by 4 (carrying into the high half) with every launched write; in fixed mode it stays unchanged; the read address never changes by itself.
- R8: Once `ib_valid` is raised it stays high with stable `ib_write`, `ib_addr` and `ib_wdata` until the cycle `ib_ready` is high, for any number of wait states.
- R9: While a transfer is in flight, a host write to 0x14 or 0x16 sees `host_ready` low until the transfer is acknowledged, while all other host accesses complete at once.
- R10: `host_rdata` shows the addressed register in the same cycle as a host read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = register write, 0 = register read |
| host_addr | input | 5 | Register address |
| host_wdata | input | 16 | Register write value |
| host_ready | output | 1 | Access accepted this cycle; low only for a launching write while busy |
| host_rdata | output | 16 | Register read value, same cycle |
| ib_valid | output | 1 | Internal request valid |
| ib_write | output | 1 | Internal request is a write |
| ib_addr | output | 32 | Internal byte address |
| ib_wdata | output | 32 | Internal write word |
| ib_ready | input | 1 | Internal acknowledge |
| ib_rdata | input | 32 | Internal read word, valid with `ib_ready` |

## Verification
A corrupted staging half or a wrong increment shows on `ib_addr`/`ib_wdata` at the very next launched transfer and in the address readback right after it, so the streaming sweep compares every word address and the final carried address. A lost or early acknowledge shows as read-data halves that do not match the arithmetic pattern the bench responder returns, or as a busy bit that stays set; wait states from zero to several cycles are swept for both directions. A wrong page compare shows at once as a nonzero read or an unexpected transfer on a page other than 4.

// File: rtl/pib_pkg.sv
package pib_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_PAGE,
    SEL_MODE,
    SEL_WAH,
    SEL_WAL,
    SEL_WDH,
    SEL_WDL,
    SEL_RAH,
    SEL_RAL,
    SEL_RDH,
    SEL_RDL
  } pib_sel_e;

  localparam int unsigned RA_W = 5;

  localparam logic [RA_W-1:0] OFS_PAGE = 5'h1f;
  localparam logic [RA_W-1:0] OFS_MODE = 5'h10;
  localparam logic [RA_W-1:0] OFS_WAH  = 5'h11;
  localparam logic [RA_W-1:0] OFS_WAL  = 5'h12;
  localparam logic [RA_W-1:0] OFS_WDH  = 5'h13;
  localparam logic [RA_W-1:0] OFS_WDL  = 5'h14;
  localparam logic [RA_W-1:0] OFS_RAH  = 5'h15;
  localparam logic [RA_W-1:0] OFS_RAL  = 5'h16;
  localparam logic [RA_W-1:0] OFS_RDH  = 5'h17;
  localparam logic [RA_W-1:0] OFS_RDL  = 5'h18;

endpackage

// File: rtl/pib_decode.sv
module pib_decode
  import pib_pkg::*;
#(
  parameter int unsigned HW          = 16,
  parameter int unsigned BRIDGE_PAGE = 4
) (
  input  logic [HW-1:0]   page,
  input  logic [RA_W-1:0] addr,
  output pib_sel_e        sel,
  output logic            launch
);

  localparam logic [HW-1:0] PAGE_ID = HW'(BRIDGE_PAGE);

  logic on_page;

  always_comb begin
    on_page = (page == PAGE_ID);
    sel     = SEL_NONE;
    if (addr == OFS_PAGE) begin
      sel = SEL_PAGE;
    end else if (on_page) begin
      case (addr)
        OFS_MODE: sel = SEL_MODE;
        OFS_WAH:  sel = SEL_WAH;
        OFS_WAL:  sel = SEL_WAL;
        OFS_WDH:  sel = SEL_WDH;
        OFS_WDL:  sel = SEL_WDL;
        OFS_RAH:  sel = SEL_RAH;
        OFS_RAL:  sel = SEL_RAL;
        OFS_RDH:  sel = SEL_RDH;
        OFS_RDL:  sel = SEL_RDL;
        default:  sel = SEL_NONE;
      endcase
    end
    launch = (sel == SEL_WDL) || (sel == SEL_RAL);
  end

endmodule

// File: rtl/pib_xfer.sv
module pib_xfer #(
  parameter int unsigned WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic [WW-1:0] start_addr,
  input  logic [WW-1:0] start_data,
  output logic          busy,
  output logic          done,
  output logic          ib_valid,
  output logic          ib_write,
  output logic [WW-1:0] ib_addr,
  output logic [WW-1:0] ib_wdata,
  input  logic          ib_ready
);

  logic          vld_q, vld_d;
  logic          wr_q;
  logic [WW-1:0] addr_q;
  logic [WW-1:0] data_q;
  logic          load_en;

  always_comb begin
    done    = vld_q && ib_ready;
    load_en = start;
    vld_d   = vld_q;
    if (done)  vld_d = 1'b0;
    if (start) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        wr_q   <= start_wr;
        addr_q <= start_addr;
        data_q <= start_data;
      end
    end
  end

  assign busy     = vld_q;
  assign ib_valid = vld_q;
  assign ib_write = wr_q;
  assign ib_addr  = addr_q;
  assign ib_wdata = data_q;

  // R8: request held steady across wait states
  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && !ib_ready) |=> (ib_valid && $stable(ib_addr) && $stable(ib_wdata) && $stable(ib_write)));

  // R9: a new launch never overlaps an open request
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !ib_valid);

  // R5/R6: a launch always raises the request next cycle
  a_r5_launch_raises_valid: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ib_valid && (ib_write == $past(start_wr)) && (ib_addr == $past(start_addr))));

endmodule

// File: rtl/pib_regs.sv
module pib_regs
  import pib_pkg::*;
#(
  parameter int unsigned HW     = 16,
  parameter int unsigned STRIDE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  pib_sel_e        sel,
  input  logic [HW-1:0]   wdata,
  input  logic            busy,
  input  logic            done_rd,
  input  logic [2*HW-1:0] bus_rdata,
  output logic [HW-1:0]   page,
  output logic [HW-1:0]   rdata,
  output logic            start,
  output logic            start_wr,
  output logic [2*HW-1:0] start_addr,
  output logic [2*HW-1:0] start_data
);

  localparam int unsigned   WW   = 2 * HW;
  localparam logic [WW-1:0] STEP = WW'(STRIDE);

  logic [HW-1:0] page_q, page_d;
  logic          incr_q, incr_d;
  logic [WW-1:0] wa_q, wa_d;
  logic [HW-1:0] wdh_q, wdh_d;
  logic [HW-1:0] wdl_q, wdl_d;
  logic [WW-1:0] ra_q, ra_d;
  logic [WW-1:0] rd_q, rd_d;

  always_comb begin
    page_d = page_q;
    incr_d = incr_q;
    wa_d   = wa_q;
    wdh_d  = wdh_q;
    wdl_d  = wdl_q;
    ra_d   = ra_q;
    rd_d   = rd_q;
    if (wr_en) begin
      case (sel)
        SEL_PAGE: page_d = wdata;
        SEL_MODE: incr_d = wdata[HW-1];
        SEL_WAH:  wa_d[WW-1:HW] = wdata;
        SEL_WAL:  wa_d[HW-1:0]  = wdata;
        SEL_WDH:  wdh_d = wdata;
        SEL_WDL: begin
          wdl_d = wdata;
          if (incr_q) wa_d = wa_q + STEP;
        end
        SEL_RAH:  ra_d[WW-1:HW] = wdata;
        SEL_RAL:  ra_d[HW-1:0]  = wdata;
        default: ;
      endcase
    end
    if (done_rd) rd_d = bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      incr_q <= 1'b0;
      wa_q   <= '0;
      wdh_q  <= '0;
      wdl_q  <= '0;
      ra_q   <= '0;
      rd_q   <= '0;
    end else begin
      page_q <= page_d;
      incr_q <= incr_d;
      wa_q   <= wa_d;
      wdh_q  <= wdh_d;
      wdl_q  <= wdl_d;
      ra_q   <= ra_d;
      rd_q   <= rd_d;
    end
  end

  always_comb begin
    start      = wr_en && ((sel == SEL_WDL) || (sel == SEL_RAL));
    start_wr   = (sel == SEL_WDL);
    start_addr = start_wr ? wa_q : {ra_q[WW-1:HW], wdata};
    start_data = {wdh_q, wdata};
  end

  always_comb begin
    case (sel)
      SEL_PAGE: rdata = page_q;
      SEL_MODE: rdata = {incr_q, {(HW-2){1'b0}}, busy};
      SEL_WAH:  rdata = wa_q[WW-1:HW];
      SEL_WAL:  rdata = wa_q[HW-1:0];
      SEL_WDH:  rdata = wdh_q;
      SEL_WDL:  rdata = wdl_q;
      SEL_RAH:  rdata = ra_q[WW-1:HW];
      SEL_RAL:  rdata = ra_q[HW-1:0];
      SEL_RDH:  rdata = rd_q[WW-1:HW];
      SEL_RDL:  rdata = rd_q[HW-1:0];
      default:  rdata = '0;
    endcase
  end

  assign page = page_q;

  // R7: streaming address advance
  a_r7_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_wr && incr_q) |=> (wa_q == $past(wa_q) + STEP));

  // R7: fixed mode keeps the write address
  a_r7_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_wr && !incr_q) |=> $stable(wa_q));

  // R6: returned word captured on acknowledge
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    done_rd |=> (rd_q == $past(bus_rdata)));

  // R9: registers never launch while the mover is occupied
  a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/pib_bridge.sv
module pib_bridge
  import pib_pkg::*;
#(
  parameter int unsigned HW          = 16,
  parameter int unsigned BRIDGE_PAGE = 4,
  parameter int unsigned STRIDE      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  logic          host_write,
  input  logic [4:0]    host_addr,
  input  logic [15:0]   host_wdata,
  output logic          host_ready,
  output logic [15:0]   host_rdata,
  output logic          ib_valid,
  output logic          ib_write,
  output logic [31:0]   ib_addr,
  output logic [31:0]   ib_wdata,
  input  logic          ib_ready,
  input  logic [31:0]   ib_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  pib_sel_e      sel;
  logic          launch;
  logic [HW-1:0] page;
  logic          busy, done, wr_en, done_rd;
  logic          start, start_wr;
  logic [31:0]   start_addr, start_data;

  pib_decode #(.HW(HW), .BRIDGE_PAGE(BRIDGE_PAGE)) u_decode (
    .page   (page),
    .addr   (host_addr),
    .sel    (sel),
    .launch (launch)
  );

  always_comb begin
    host_ready = !(busy && host_write && launch);
    wr_en      = host_valid && host_write && host_ready;
    done_rd    = done && !ib_write;
  end

  pib_regs #(.HW(HW), .STRIDE(STRIDE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .wr_en      (wr_en),
    .sel        (sel),
    .wdata      (host_wdata),
    .busy       (busy),
    .done_rd    (done_rd),
    .bus_rdata  (ib_rdata),
    .page       (page),
    .rdata      (host_rdata),
    .start      (start),
    .start_wr   (start_wr),
    .start_addr (start_addr),
    .start_data (start_data)
  );

  pib_xfer #(.WW(2*HW)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (start),
    .start_wr   (start_wr),
    .start_addr (start_addr),
    .start_data (start_data),
    .busy       (busy),
    .done       (done),
    .ib_valid   (ib_valid),
    .ib_write   (ib_write),
    .ib_addr    (ib_addr),
    .ib_wdata   (ib_wdata),
    .ib_ready   (ib_ready)
  );

  // R9: host stalled only for launching writes while occupied
  a_r9_stall_scope: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!host_ready) |-> (ib_valid && host_write));

endmodule

// File: tb/tb_pib_bridge.sv
module tb_pib_bridge;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid, host_write;
  logic [4:0]  host_addr;
  logic [15:0] host_wdata;
  logic        host_ready;
  logic [15:0] host_rdata;
  logic        ib_valid, ib_write, ib_ready;
  logic [31:0] ib_addr, ib_wdata, ib_rdata;

  int checks = 0;
  int errors = 0;
  int ws = 0;
  int wcnt = 0;
  int n_xfer = 0;
  logic [31:0] lg_addr, lg_data;
  logic        lg_wr;
  bit          finished = 0;

  always #4 clk = ~clk;

  pib_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
    .ib_valid(ib_valid), .ib_write(ib_write), .ib_addr(ib_addr),
    .ib_wdata(ib_wdata), .ib_ready(ib_ready), .ib_rdata(ib_rdata)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  assign ib_rdata = pat(ib_addr);

  always @(negedge clk) begin
    if (!ib_valid) begin
      wcnt     <= 0;
      ib_ready <= 1'b0;
    end else begin
      ib_ready <= (wcnt >= ws);
      wcnt     <= wcnt + 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n && ib_valid && ib_ready) begin
      n_xfer  <= n_xfer + 1;
      lg_addr <= ib_addr;
      lg_data <= ib_wdata;
      lg_wr   <= ib_write;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hwr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    #1;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic hrd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    #1;
    d = host_rdata;
    host_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] m;
    for (int k = 0; k < 100; k++) begin
      hrd(5'h10, m);
      if (m[0] == 1'b0) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int nx;
    host_valid = 0; host_write = 0; host_addr = 0; host_wdata = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state
    hrd(5'h1f, r);  chk("R1", "page after reset", {16'h0, r}, 32'h0);
    chk("R1", "ib_valid after reset", {31'h0, ib_valid}, 32'h0);
    chk("R1", "host_ready after reset", {31'h0, host_ready}, 32'h1);
    hwr(5'h1f, 16'h4);
    for (int a = 16; a <= 24; a++) begin
      hrd(5'(a), r); chk("R1", $sformatf("reg %h after reset", a), {16'h0, r}, 32'h0);
    end

    // R2: page sweep
    for (int p = 0; p < 8; p++) begin
      hwr(5'h1f, 16'(p));
      hrd(5'h1f, r); chk("R2", $sformatf("page readback %0d", p), {16'h0, r}, p);
      nx = n_xfer;
      hwr(5'h13, 16'(16'h1000 + p));
      hwr(5'h14, 16'h0);
      repeat (3) @(negedge clk);
      if (p != 4) chk("R2", $sformatf("no transfer off page %0d", p), n_xfer, nx);
      else        wait_idle();
      hrd(5'h13, r);
      chk("R2", $sformatf("bridge reg on page %0d", p), {16'h0, r}, (p == 4) ? 32'h1004 : 32'h0);
    end
    hwr(5'h1f, 16'h4);
    hrd(5'h13, r); chk("R2", "page 4 value kept", {16'h0, r}, 32'h1004);

    // R4: staging only, no transfers
    nx = n_xfer;
    hwr(5'h11, 16'hA1B2); hwr(5'h12, 16'hC3D4); hwr(5'h13, 16'hE5F6); hwr(5'h15, 16'h0718);
    repeat (3) @(negedge clk);
    chk("R4", "staging writes start nothing", n_xfer, nx);
    hrd(5'h11, r); chk("R4", "0x11 readback", {16'h0, r}, 32'hA1B2);
    hrd(5'h12, r); chk("R4", "0x12 readback", {16'h0, r}, 32'hC3D4);
    hrd(5'h13, r); chk("R4", "0x13 readback", {16'h0, r}, 32'hE5F6);
    hrd(5'h15, r); chk("R4", "0x15 readback", {16'h0, r}, 32'h0718);

    // R5/R7/R8: fixed-mode writes across wait states
    hwr(5'h10, 16'h0);
    hrd(5'h10, r); chk("R3", "mode fixed readback", {16'h0, r}, 32'h0);
    hwr(5'h11, 16'h1234); hwr(5'h12, 16'h5670);
    for (int w = 0; w < 4; w++) begin
      ws = w;
      nx = n_xfer;
      hwr(5'h13, 16'(16'hBEE0 + w));
      hwr(5'h14, 16'(16'h0100 * w + 7));
      wait_idle();
      chk("R8", $sformatf("one write ws=%0d", w), n_xfer, nx + 1);
      chk("R5", $sformatf("write addr ws=%0d", w), lg_addr, 32'h1234_5670);
      chk("R5", $sformatf("write data ws=%0d", w), lg_data, {16'(16'hBEE0 + w), 16'(16'h0100 * w + 7)});
      chk("R5", "write flag", {31'h0, lg_wr}, 32'h1);
      hrd(5'h12, r); chk("R7", "fixed addr low unchanged", {16'h0, r}, 32'h5670);
      hrd(5'h14, r); chk("R4", "0x14 readback", {16'h0, r}, 32'(16'h0100 * w + 7));
    end

    // R7: streaming with carry
    hwr(5'h10, 16'hFFFF);
    hrd(5'h10, r); chk("R3", "mode incr readback", {16'h0, r}, 32'h8000);
    hwr(5'h11, 16'h0000); hwr(5'h12, 16'hFFF8);
    for (int i = 0; i < 4; i++) begin
      ws = i;
      hwr(5'h13, 16'(16'h0111 * i));
      hwr(5'h14, 16'(16'hF000 + i));
      wait_idle();
      chk("R7", $sformatf("stream addr word %0d", i), lg_addr, 32'h0000_FFF8 + 32'(4 * i));
      chk("R5", $sformatf("stream data word %0d", i), lg_data, {16'(16'h0111 * i), 16'(16'hF000 + i)});
    end
    hrd(5'h11, r); chk("R7", "carried addr high", {16'h0, r}, 32'h0001);
    hrd(5'h12, r); chk("R7", "carried addr low", {16'h0, r}, 32'h0008);

    // R6/R10: reads across wait states, incr mode still on
    for (int w = 0; w < 5; w++) begin
      logic [31:0] a32;
      ws = w;
      a32 = 32'h00C0_0000 + 32'(w * 32'h0001_0104);
      hwr(5'h15, a32[31:16]);
      hwr(5'h16, a32[15:0]);
      wait_idle();
      chk("R6", $sformatf("read flag ws=%0d", w), {31'h0, lg_wr}, 32'h0);
      chk("R6", $sformatf("read addr ws=%0d", w), lg_addr, a32);
      hrd(5'h17, r); chk("R10", $sformatf("read data high ws=%0d", w), {16'h0, r}, {16'h0, pat(a32)[31:16]});
      hrd(5'h18, r); chk("R10", $sformatf("read data low ws=%0d", w), {16'h0, r}, {16'h0, pat(a32)[15:0]});
      hrd(5'h16, r); chk("R7", "read addr not advanced", {16'h0, r}, {16'h0, a32[15:0]});
      hwr(5'h17, 16'hDEAD); hwr(5'h18, 16'hBEEF);
      hrd(5'h18, r); chk("R6", "read data write ignored", {16'h0, r}, {16'h0, pat(a32)[15:0]});
    end

    // R9/R3: busy stall
    ws = 6;
    hwr(5'h10, 16'h0);
    hwr(5'h11, 16'h0000); hwr(5'h12, 16'h0040);
    nx = n_xfer;
    hwr(5'h14, 16'h1111);
    hrd(5'h10, r); chk("R3", "busy bit while in flight", {16'h0, r}, 32'h0001);
    hwr(5'h13, 16'h2222);
    chk("R9", "staging write completes while busy", n_xfer, nx);
    @(negedge clk);
    host_valid = 1; host_write = 1; host_addr = 5'h14; host_wdata = 16'h3333;
    #1;
    chk("R9", "launch stalled while busy", {31'h0, host_ready}, 32'h0);
    while (!host_ready) @(negedge clk);
    chk("R9", "stall ends at acknowledge", n_xfer, nx + 1);
    @(negedge clk);
    host_valid = 0; host_write = 0;
    wait_idle();
    chk("R9", "second write done", n_xfer, nx + 2);
    chk("R9", "second write data", lg_data, 32'h2222_3333);
    hrd(5'h10, r); chk("R3", "busy clear when idle", {16'h0, r}, 32'h0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule